// File: doc/BRIEF.md
# Multi-Format Serial Transmitter

This block sends bytes over an asynchronous serial line. A write loads one data word into a holding stage. The transmit path then moves that word into a shift stage and places it on the line as one complete frame. The shift stage advances only on cycles where `bit_tick` is high, so the time between two ticks is one bit period. The baud-rate generator that produces `bit_tick` is outside this block. The line rests high while nothing is being sent.

Four frame layouts are available:
- eight data bits and one stop bit;
- eight data bits, a parity bit and one stop bit;
- eight data bits and two stop bits;
- nine data bits and one stop bit.

The single control input `wr_ctl` serves two purposes. In the nine-bit layout it is the top data bit. In the parity layout it selects even or odd parity.

Two flags report progress: "holding empty" and "transmission complete". Each flag has its own interrupt enable, and the block combines the enabled flags onto one request line. The asynchronous reset input is released through an internal two-stage synchronizer. The block therefore starts working on the third rising clock edge after `rst_n` goes high.

Top module: `serial_tx_core`

## Requirements
- R1: While in reset, and until the first frame starts, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1. `irq` is then high only if `tx_done_ie` or `hold_empty_ie` is set.
- R2: With `wr_fmt` = 0, a frame is a 0 start bit, then eight data bits least significant first, then one stop bit of 1. Each bit holds `txd` for exactly one tick interval, and `txd` changes only on a cycle with `bit_tick` high.
- R3: With `wr_fmt` = 3, the frame carries nine data bits. The ninth bit is `wr_ctl` and is sent after the eight bits of `wr_data`, followed by one stop bit.
- R4: With `wr_fmt` = 1, a parity bit follows the eight data bits, then one stop bit. When `wr_ctl` = 0 the parity is even (parity bit = XOR of the data bits). When `wr_ctl` = 1 the parity is odd (the inverse).
- R5: With `wr_fmt` = 2, eight data bits are followed by two stop bits of 1.
- R6: An accepted write clears `hold_empty` on the next cycle. `hold_empty` returns to 1 on the cycle after the tick that moves the held word into the shift stage. That same edge drives the start bit onto `txd`.
- R7: `tx_done` goes to 1 on the cycle after the tick that ends the last stop bit, if no word is held at that point. An accepted write clears it on the next cycle.
- R8: A write presented while `hold_empty` is 0 is ignored. The held word, the flags and the later line output are unaffected by it.
- R9: `irq` is high exactly when (`hold_empty` and `hold_empty_ie`) or (`tx_done` and `tx_done_ie`).
- R10: If a word is held when the last stop bit ends, the next frame's start bit follows immediately, with no idle bit between the frames.
- R11: `wr_fmt` and `wr_ctl` are captured with the accepted write. Changing them afterwards does not alter a frame that is already held or in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Data word (DATA_W) |
| wr_ctl | input | 1 | Ninth data bit, or parity sense (0 even, 1 odd) |
| wr_fmt | input | 2 | Frame layout: 0 = 8+1 stop, 1 = 8+parity+1 stop, 2 = 8+2 stop, 3 = 9+1 stop |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| hold_empty_ie | input | 1 | Interrupt enable for holding-empty |
| tx_done_ie | input | 1 | Interrupt enable for transmission complete |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding stage can accept a write |
| tx_done | output | 1 | Line idle with nothing pending |
| irq | output | 1 | Combined enabled interrupt request |

## Verification
The assertions check the following on every cycle:
- the line moves only on tick cycles;
- a start bit appears whenever the holding stage empties;
- `tx_done` implies both an idle line and an empty holding stage;
- an accepted write clears both flags;
- a refused write leaves the held word untouched.

Some properties need whole frames and can only be shown by the bench's scenarios. These are the bit order, the parity sense, the number of stop bits, the placement of the ninth bit, the gap-free chaining of two frames, and the fact that the layout is captured at write time. The bench checks them with a cycle-accurate queue model compared on every clock.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    FMT_8N1 = 2'd0,
    FMT_8P1 = 2'd1,
    FMT_8N2 = 2'd2,
    FMT_9N1 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic ctl;
    fmt_e fmt;
  } frame_cfg_t;

endpackage

// File: rtl/stx_rst_sync.sv
module stx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  stx_pkg::frame_cfg_t  wr_cfg,
  input  logic                 take,
  output logic                 full,
  output logic                 accept,
  output logic [DATA_W-1:0]    data_q,
  output stx_pkg::frame_cfg_t  cfg_q
);

  logic                full_q, full_n;
  logic [DATA_W-1:0]   data_n;
  stx_pkg::frame_cfg_t cfg_n;

  assign accept = wr_en & ~full_q;
  assign full   = full_q;

  always_comb begin
    full_n = full_q;
    data_n = data_q;
    cfg_n  = cfg_q;
    if (take) begin
      full_n = 1'b0;
    end
    if (accept) begin
      full_n = 1'b1;
      data_n = wr_data;
      cfg_n  = wr_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      cfg_q  <= '{ctl: 1'b0, fmt: stx_pkg::FMT_8N1};
    end else begin
      full_q <= full_n;
      if (accept) begin
        data_q <= data_n;
        cfg_q  <= cfg_n;
      end
    end
  end

endmodule

// File: rtl/stx_framer.sv
module stx_framer #(
  parameter int DATA_W = 8,
  localparam int PAY_W = DATA_W + 2,
  localparam int CNT_W = $clog2(DATA_W + 4)
) (
  input  logic [DATA_W-1:0]   data,
  input  stx_pkg::frame_cfg_t cfg,
  output logic [PAY_W-1:0]    payload,
  output logic [CNT_W-1:0]    len
);

  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DATA_W + 3);

  logic slot;

  always_comb begin
    case (cfg.fmt)
      stx_pkg::FMT_8P1: slot = (^data) ^ cfg.ctl;
      stx_pkg::FMT_9N1: slot = cfg.ctl;
      default:          slot = 1'b1;
    endcase
  end

  assign payload = {1'b1, slot, data};
  assign len     = (cfg.fmt == stx_pkg::FMT_8N1) ? LEN_SHORT : LEN_LONG;

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int DATA_W = 8,
  localparam int PAY_W = DATA_W + 2,
  localparam int CNT_W = $clog2(DATA_W + 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pending,
  input  logic [PAY_W-1:0] payload,
  input  logic [CNT_W-1:0] len,
  output logic             txd,
  output logic             take,
  output logic             done
);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PAY_W-1:0] sr_q, sr_n;
  logic             txd_q, txd_n;
  logic             last_bit;

  assign last_bit = busy_q & (cnt_q == CNT_W'(1));
  assign take     = tick & pending & (~busy_q | last_bit);
  assign done     = tick & last_bit & ~pending;
  assign txd      = txd_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    sr_n   = sr_q;
    txd_n  = txd_q;
    if (take) begin
      busy_n = 1'b1;
      cnt_n  = len;
      sr_n   = payload;
      txd_n  = 1'b0;
    end else if (tick && busy_q) begin
      if (last_bit) begin
        busy_n = 1'b0;
        txd_n  = 1'b1;
      end else begin
        txd_n = sr_q[0];
        sr_n  = {1'b1, sr_q[PAY_W-1:1]};
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '1;
      txd_q  <= 1'b1;
    end else if (tick) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      txd_q  <= txd_n;
    end
  end

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
  parameter int DATA_W = 8,
  localparam int PAY_W = DATA_W + 2,
  localparam int CNT_W = $clog2(DATA_W + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ctl,
  input  logic [1:0]        wr_fmt,
  input  logic              bit_tick,
  input  logic              hold_empty_ie,
  input  logic              tx_done_ie,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              irq
);

  logic                rst_sync_n;
  logic                full;
  logic                accept;
  logic                take;
  logic                done;
  logic [DATA_W-1:0]   hold_data;
  stx_pkg::frame_cfg_t hold_cfg;
  stx_pkg::frame_cfg_t wr_cfg;
  logic [PAY_W-1:0]    payload;
  logic [CNT_W-1:0]    len;
  logic                tc_q, tc_n;

  assign wr_cfg = '{ctl: wr_ctl, fmt: stx_pkg::fmt_e'(wr_fmt)};

  stx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_cfg  (wr_cfg),
    .take    (take),
    .full    (full),
    .accept  (accept),
    .data_q  (hold_data),
    .cfg_q   (hold_cfg)
  );

  stx_framer #(.DATA_W(DATA_W)) u_framer (
    .data    (hold_data),
    .cfg     (hold_cfg),
    .payload (payload),
    .len     (len)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (bit_tick),
    .pending (full),
    .payload (payload),
    .len     (len),
    .txd     (txd),
    .take    (take),
    .done    (done)
  );

  always_comb begin
    tc_n = tc_q;
    if (accept) begin
      tc_n = 1'b0;
    end else if (done) begin
      tc_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tc_q <= 1'b1;
    end else begin
      tc_q <= tc_n;
    end
  end

  assign hold_empty = ~full;
  assign tx_done    = tc_q;
  assign irq        = (hold_empty & hold_empty_ie) | (tc_q & tx_done_ie);

endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              bit_tick,
  input logic              txd,
  input logic              hold_empty,
  input logic              tx_done,
  input logic [DATA_W-1:0] hold_data
);

  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  assert_start_on_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> !txd);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_empty) |=> (!hold_empty && !tx_done));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (txd && hold_empty));

  assert_refused_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold_empty && !bit_tick) |=> (!hold_empty && $stable(hold_data)));

endmodule

bind serial_tx_core stx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .bit_tick   (bit_tick),
  .txd        (txd),
  .hold_empty (hold_empty),
  .tx_done    (tx_done),
  .hold_data  (hold_data)
);

// File: tb/tb_serial_tx_core.sv
`timescale 1ns/100ps
module tb_serial_tx_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       wr_ctl;
  logic [1:0] wr_fmt;
  logic       bit_tick;
  logic       hold_empty_ie;
  logic       tx_done_ie;
  logic       txd, hold_empty, tx_done, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_tx_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .wr_fmt(wr_fmt), .bit_tick(bit_tick),
    .hold_empty_ie(hold_empty_ie), .tx_done_ie(tx_done_ie),
    .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done), .irq(irq)
  );

  // reference model state
  int   m_rc = 0;
  bit   m_hold = 0;
  bit   m_active = 0;
  bit   m_line = 1;
  bit   m_tc = 1;
  bit [7:0] m_hdata = 0;
  bit   m_hctl = 0;
  bit [1:0] m_hfmt = 0;
  bit [1:0] m_cur_fmt = 0;
  bit   m_q[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void m_reset();
    m_hold = 0; m_active = 0; m_line = 1; m_tc = 1; m_q.delete();
  endfunction

  function automatic void m_build();
    m_q.delete();
    for (int i = 0; i < 8; i++) m_q.push_back(m_hdata[i]);
    if (m_hfmt == 2'd1) m_q.push_back((^m_hdata) ^ m_hctl);
    if (m_hfmt == 2'd3) m_q.push_back(m_hctl);
    m_q.push_back(1'b1);
    if (m_hfmt == 2'd2) m_q.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    bit acc, tcset;
    if (!rst_n) begin
      m_rc = 0; m_reset();
    end else if (m_rc < 2) begin
      m_rc++; m_reset();
    end else begin
      acc = wr_en && !m_hold;
      tcset = 0;
      if (bit_tick) begin
        if (m_active && m_q.size() > 0) begin
          m_line = m_q.pop_front();
        end else if (m_hold) begin
          m_line = 0; m_build(); m_hold = 0; m_active = 1; m_cur_fmt = m_hfmt;
        end else if (m_active) begin
          m_active = 0; m_line = 1; tcset = 1;
        end
      end
      if (acc) begin
        m_hold = 1; m_hdata = wr_data; m_hctl = wr_ctl; m_hfmt = wr_fmt; m_tc = 0;
      end else if (tcset) begin
        m_tc = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && m_rc >= 2) begin
        string lreq;
        bit exp_irq;
        case (m_cur_fmt)
          2'd1: lreq = "R4 line (parity frame)";
          2'd2: lreq = "R5 line (two-stop frame)";
          2'd3: lreq = "R3 line (nine-bit frame)";
          default: lreq = "R2 line (plain frame)";
        endcase
        check(txd === m_line, lreq, txd, m_line);
        check(hold_empty === !m_hold, "R6 hold_empty", hold_empty, !m_hold);
        check(tx_done === m_tc, "R7 tx_done", tx_done, m_tc);
        exp_irq = (!m_hold && hold_empty_ie) || (m_tc && tx_done_ie);
        check(irq === exp_irq, "R9 irq", irq, exp_irq);
      end
    end
  end

  // bit tick: one pulse every 4 clocks
  initial begin
    int tcnt = 0;
    bit_tick = 0;
    forever begin
      @(negedge clk);
      bit_tick = (tcnt == 3);
      tcnt = (tcnt + 1) % 4;
    end
  end

  task automatic send(input logic [7:0] d, input logic c, input logic [1:0] f);
    @(negedge clk);
    while (!hold_empty) @(negedge clk);
    wr_en = 1; wr_data = d; wr_ctl = c; wr_fmt = f;
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00; wr_ctl = ~c; wr_fmt = ~f;  // R11: inputs change after capture
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!tx_done) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; wr_ctl = 0; wr_fmt = 0;
    hold_empty_ie = 0; tx_done_ie = 0;
    repeat (3) @(negedge clk);
    #1;
    check(txd === 1'b1, "R1 txd in reset", txd, 1);
    check(hold_empty === 1'b1, "R1 hold_empty in reset", hold_empty, 1);
    check(tx_done === 1'b1, "R1 tx_done in reset", tx_done, 1);
    check(irq === 1'b0, "R1 irq masked in reset", irq, 0);
    tx_done_ie = 1;
    #0.5;
    check(irq === 1'b1, "R1 irq with done enable", irq, 1);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    send(8'hA5, 1'b0, 2'd0);          // R2
    wait_done();
    hold_empty_ie = 1; tx_done_ie = 0;
    send(8'h3C, 1'b0, 2'd1);          // R4 even parity
    wait_done();
    send(8'h07, 1'b1, 2'd1);          // R4 odd parity
    wait_done();
    send(8'h81, 1'b0, 2'd2);          // R5
    wait_done();
    tx_done_ie = 1;
    send(8'h55, 1'b1, 2'd3);          // R3 ninth bit 1
    wait_done();
    send(8'hF0, 1'b0, 2'd3);          // R3 ninth bit 0
    send(8'h0F, 1'b1, 2'd1);          // R10 back-to-back
    send(8'hC3, 1'b0, 2'd2);          // R10
    wait_done();

    // R8: second write while holding stage is full
    @(negedge clk);
    while (!hold_empty || bit_tick) @(negedge clk);
    wr_en = 1; wr_data = 8'h11; wr_ctl = 0; wr_fmt = 2'd0;
    @(negedge clk);
    wr_data = 8'hEE; wr_fmt = 2'd1; wr_ctl = 1;
    #1;
    check(hold_empty === 1'b0, "R8 refused write leaves full", hold_empty, 0);
    @(negedge clk);
    wr_en = 0;
    #1;
    check(hold_empty === 1'b0, "R8 still holding first word", hold_empty, 0);
    wait_done();
    repeat (8) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule